// File: doc/BRIEF.md
# Observation Clock Generator

This block derives three slow, observable clock outputs from a set of source waveforms and a reference waveform. An observation path picks one of several source clocks and divides it by a programmable ratio. A per-divider enable bit can stop the divider, and a bit in a shared enable register gates the path onto its pin. The same enable register also gates an auxiliary pin that carries the reference clock with no division. A separate bypass divider, which has no enable bit, divides the reference clock and runs at all times.

All logic runs in one fast system clock domain. The source and reference inputs are sampled as levels, and each divider counts their transitions. The outputs are therefore registered waveforms that are safe to route to a pad or a frequency counter. Software configures the block through a simple single-cycle register bus. The source selection is switched by a disable-switch-enable rule: a write to the select register is dropped while the observation gate is open, so the source can never change under a running output.

Top module: `obs_clk_unit`

## Requirements
- R1: After reset, every register reads zero, and obs_clk_o and aux_clk_o stay low.
- R2: The observation divider register is at offset 0x124, with its ratio field in bits 4:0. With the divider and the gate enabled, obs_clk_o runs at the selected source frequency divided by (field + 1).
- R3: Bit 15 of the observation divider register enables that divider. While the bit is clear, obs_clk_o is held low.
- R4: The enable register is at offset 0x148. Bit 1 gates obs_clk_o: when the bit is clear, the output is low. Bit 0 gates aux_clk_o, which carries the reference clock at its own frequency with no division.
- R5: The source select register is at offset 0x104. Its low SEL_W bits choose the index of the source input that feeds the observation divider.
- R6: A write to the source select register is ignored while enable bit 1 is set. Both the readback value and the source in use stay unchanged.
- R7: The bypass divider register is at offset 0x12C, with its ratio field in bits 4:0. bp_clk_o runs at the reference frequency divided by (field + 1), and it has no enable or gate.
- R8: A read returns the stored fields with every unused bit at zero. A read from an unmapped offset returns zero.
- R9: The ratio field covers both extremes: a field value of 0 passes the source frequency through, and a value of 31 divides it by 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| src_clk_i | input | N_SRC | Candidate observation source waveforms |
| ref_clk_i | input | 1 | Reference clock waveform |
| obs_clk_o | output | 1 | Selected, divided and gated observation clock |
| aux_clk_o | output | 1 | Gated, undivided reference clock |
| bp_clk_o | output | 1 | Reference clock divided by the bypass ratio |

## Verification
The bound checker watches five rules on every cycle:
- each gate bit forces its output low;
- a cleared divider enable holds obs_clk_o low from the following cycle;
- the source select value never moves while the observation gate is open;
- an unmapped offset always reads back as zero.

Output frequencies cannot be judged cycle by cycle, so the bench scenarios check them. Each scenario counts rising edges over a fixed window and compares the count with the expected ratio. The scenarios cover the extremes of the ratio field, several different sources, the dropped select write observed at the output, and the bypass divider.

// File: rtl/obs_clk_pkg.sv
package obs_clk_pkg;

   // Register byte offsets (software-visible map)
   localparam int unsigned OFS_SRC_SEL = 32'h104;
   localparam int unsigned OFS_OBS_DIV = 32'h124;
   localparam int unsigned OFS_BP_DIV  = 32'h12C;
   localparam int unsigned OFS_GATE    = 32'h148;

   // Field positions
   localparam int unsigned DIV_EN_BIT   = 15;
   localparam int unsigned GATE_AUX_BIT = 0;
   localparam int unsigned GATE_OBS_BIT = 1;

   // Divider channel identifiers used by the generate loop in the top
   typedef enum logic [0:0] {
      CH_OBS = 1'b0,
      CH_BP  = 1'b1
   } div_ch_e;

endpackage

// File: rtl/obs_clk_regs.sv
module obs_clk_regs
   import obs_clk_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32,
   parameter int SEL_W   = 2,
   parameter int RATIO_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [SEL_W-1:0]   sel_q,
   output logic [RATIO_W-1:0] obs_ratio_q,
   output logic               obs_en_q,
   output logic [RATIO_W-1:0] bp_ratio_q,
   output logic               obs_gate_q,
   output logic               aux_gate_q
);

   localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFS_SRC_SEL);
   localparam logic [ADDR_W-1:0] A_ODIV = ADDR_W'(OFS_OBS_DIV);
   localparam logic [ADDR_W-1:0] A_BDIV = ADDR_W'(OFS_BP_DIV);
   localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(OFS_GATE);

   logic hit_sel, hit_odiv, hit_bdiv, hit_gate;
   logic wdata_unused;

   assign hit_sel  = (bus_addr == A_SEL);
   assign hit_odiv = (bus_addr == A_ODIV);
   assign hit_bdiv = (bus_addr == A_BDIV);
   assign hit_gate = (bus_addr == A_GATE);
   assign wdata_unused = ^bus_wdata;

   // Source select: accepted only while the observation gate is closed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (bus_wr && hit_sel && !obs_gate_q) begin
         sel_q <= bus_wdata[SEL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obs_ratio_q <= '0;
         obs_en_q    <= 1'b0;
      end else if (bus_wr && hit_odiv) begin
         obs_ratio_q <= bus_wdata[RATIO_W-1:0];
         obs_en_q    <= bus_wdata[DIV_EN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_ratio_q <= '0;
      end else if (bus_wr && hit_bdiv) begin
         bp_ratio_q <= bus_wdata[RATIO_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obs_gate_q <= 1'b0;
         aux_gate_q <= 1'b0;
      end else if (bus_wr && hit_gate) begin
         obs_gate_q <= bus_wdata[GATE_OBS_BIT];
         aux_gate_q <= bus_wdata[GATE_AUX_BIT];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_sel) begin
         bus_rdata[SEL_W-1:0] = sel_q;
      end else if (hit_odiv) begin
         bus_rdata[RATIO_W-1:0] = obs_ratio_q;
         bus_rdata[DIV_EN_BIT]  = obs_en_q;
      end else if (hit_bdiv) begin
         bus_rdata[RATIO_W-1:0] = bp_ratio_q;
      end else if (hit_gate) begin
         bus_rdata[GATE_OBS_BIT] = obs_gate_q;
         bus_rdata[GATE_AUX_BIT] = aux_gate_q;
      end
   end

endmodule

// File: rtl/obs_clk_srcsel.sv
module obs_clk_srcsel #(
   parameter int N_SRC = 4,
   parameter int SEL_W = 2
) (
   input  logic [N_SRC-1:0] src_lvl,
   input  logic [SEL_W-1:0] sel,
   output logic             picked
);

   logic [N_SRC-1:0] hit;

   // AND-OR mux; a select value beyond N_SRC-1 picks nothing (low)
   for (genvar gi = 0; gi < N_SRC; gi++) begin : g_leg
      assign hit[gi] = src_lvl[gi] && (sel == SEL_W'(gi));
   end

   assign picked = |hit;

endmodule

// File: rtl/obs_clk_divider.sv
module obs_clk_divider #(
   parameter int RATIO_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_lvl,
   input  logic               en,
   input  logic [RATIO_W-1:0] ratio,
   output logic               out_q
);

   logic               prev_q;
   logic [RATIO_W-1:0] cnt_q;
   logic               edge_seen;
   logic               wrap;

   assign edge_seen = in_lvl ^ prev_q;
   // >= so that lowering the ratio while running never overruns the count
   assign wrap      = (cnt_q >= ratio);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         cnt_q  <= '0;
         out_q  <= 1'b0;
      end else begin
         prev_q <= in_lvl;
         if (!en) begin
            cnt_q <= '0;
            out_q <= 1'b0;
         end else if (edge_seen) begin
            if (wrap) begin
               cnt_q <= '0;
               out_q <= ~out_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/obs_clk_unit.sv
module obs_clk_unit
   import obs_clk_pkg::*;
#(
   parameter int N_SRC   = 4,
   parameter int RATIO_W = 5,
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_SRC-1:0]  src_clk_i,
   input  logic              ref_clk_i,
   output logic              obs_clk_o,
   output logic              aux_clk_o,
   output logic              bp_clk_o
);

   localparam int SEL_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1;
   localparam int N_DIVS = 2;

   // Elaboration-time parameter checks
   if (N_SRC < 2) begin : g_chk_src
      $error("obs_clk_unit: N_SRC must be at least 2");
   end
   if (RATIO_W < 1 || RATIO_W > int'(DIV_EN_BIT)) begin : g_chk_ratio
      $error("obs_clk_unit: RATIO_W must lie in 1..15");
   end
   if (DATA_W < 16) begin : g_chk_data
      $error("obs_clk_unit: DATA_W must hold the divider enable bit");
   end
   if (ADDR_W < 9) begin : g_chk_addr
      $error("obs_clk_unit: ADDR_W too small for the register map");
   end

   logic [SEL_W-1:0]   sel_q;
   logic [RATIO_W-1:0] obs_ratio_q, bp_ratio_q;
   logic               obs_en_q, obs_gate, aux_gate;
   logic [N_SRC-1:0]   src_q;
   logic               ref_q;
   logic               picked;

   obs_clk_regs #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .SEL_W   (SEL_W),
      .RATIO_W (RATIO_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .sel_q       (sel_q),
      .obs_ratio_q (obs_ratio_q),
      .obs_en_q    (obs_en_q),
      .bp_ratio_q  (bp_ratio_q),
      .obs_gate_q  (obs_gate),
      .aux_gate_q  (aux_gate)
   );

   // Sample the waveform inputs once into the system domain
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         ref_q <= 1'b0;
      end else begin
         src_q <= src_clk_i;
         ref_q <= ref_clk_i;
      end
   end

   obs_clk_srcsel #(
      .N_SRC (N_SRC),
      .SEL_W (SEL_W)
   ) u_srcsel (
      .src_lvl (src_q),
      .sel     (sel_q),
      .picked  (picked)
   );

   // Divider channels share one implementation
   logic [N_DIVS-1:0] div_in, div_en, div_out;
   logic [RATIO_W-1:0] div_ratio [N_DIVS];

   for (genvar gd = 0; gd < N_DIVS; gd++) begin : g_div
      if (gd == int'(CH_OBS)) begin : g_obs
         assign div_in[gd]    = picked;
         assign div_en[gd]    = obs_en_q;
         assign div_ratio[gd] = obs_ratio_q;
      end else begin : g_bp
         assign div_in[gd]    = ref_q;
         assign div_en[gd]    = 1'b1;
         assign div_ratio[gd] = bp_ratio_q;
      end

      obs_clk_divider #(
         .RATIO_W (RATIO_W)
      ) u_div (
         .clk    (clk),
         .rst_n  (rst_n),
         .in_lvl (div_in[gd]),
         .en     (div_en[gd]),
         .ratio  (div_ratio[gd]),
         .out_q  (div_out[gd])
      );
   end

   assign obs_clk_o = div_out[CH_OBS] & obs_gate;
   assign aux_clk_o = ref_q & aux_gate;
   assign bp_clk_o  = div_out[CH_BP];

endmodule

// File: rtl/obs_clk_unit_chk.sv
module obs_clk_unit_chk
   import obs_clk_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int SEL_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [SEL_W-1:0]  sel_q,
   input logic              obs_en_q,
   input logic              obs_gate,
   input logic              aux_gate,
   input logic              obs_clk_o,
   input logic              aux_clk_o
);

   logic mapped;
   assign mapped = (bus_addr == ADDR_W'(OFS_SRC_SEL)) ||
                   (bus_addr == ADDR_W'(OFS_OBS_DIV)) ||
                   (bus_addr == ADDR_W'(OFS_BP_DIV))  ||
                   (bus_addr == ADDR_W'(OFS_GATE));

   p_obs_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !obs_gate |-> !obs_clk_o);

   p_aux_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !aux_gate |-> !aux_clk_o);

   p_div_off_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !obs_en_q |=> (obs_en_q || !obs_clk_o));

   p_sel_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      obs_gate |=> $stable(sel_q));

   p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (bus_rdata == '0));

endmodule

bind obs_clk_unit obs_clk_unit_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .SEL_W  (SEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .sel_q     (sel_q),
   .obs_en_q  (obs_en_q),
   .obs_gate  (obs_gate),
   .aux_gate  (aux_gate),
   .obs_clk_o (obs_clk_o),
   .aux_clk_o (aux_clk_o)
);

// File: tb/obs_clk_unit_bench.sv
module obs_clk_unit_bench;

   localparam int N_SRC  = 4;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;
   localparam int WIN    = 2000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic [N_SRC-1:0]  src_clk_i = '0;
   logic              ref_clk_i = 1'b0;
   logic              obs_clk_o, aux_clk_o, bp_clk_o;

   int n_tests = 0;
   int n_fail  = 0;
   int done_cnt = 0;
   bit finished = 1'b0;

   // Scoreboard queues: channel (0 obs, 1 aux, 2 bypass), expected edges, tag
   int    ch_q[$];
   int    exp_q[$];
   string tag_q[$];

   always #5 clk = ~clk;

   obs_clk_unit #(
      .N_SRC (N_SRC), .RATIO_W (5), .ADDR_W (ADDR_W), .DATA_W (DATA_W)
   ) u_obs_clk_unit (
      .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .src_clk_i (src_clk_i),
      .ref_clk_i (ref_clk_i), .obs_clk_o (obs_clk_o), .aux_clk_o (aux_clk_o),
      .bp_clk_o (bp_clk_o)
   );

   // Waveform sources: periods 4, 6, 10, 14 cycles; reference period 8
   initial begin
      int cnt [5] = '{0, 0, 0, 0, 0};
      int half [5] = '{2, 3, 5, 7, 4};
      forever begin
         @(negedge clk);
         for (int i = 0; i < 5; i++) begin
            cnt[i]++;
            if (cnt[i] == half[i]) begin
               cnt[i] = 0;
               if (i < 4) src_clk_i[i] = ~src_clk_i[i];
               else       ref_clk_i = ~ref_clk_i;
            end
         end
      end
   end

   task automatic chk(input string req, input int act, input int expv, input int tol);
      n_tests++;
      if (act > expv + tol || act < expv - tol) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic wr(input int a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [DATA_W-1:0] d);
      @(negedge clk);
      bus_addr = ADDR_W'(a);
      #1 d = bus_rdata;
   endtask

   // Driver: push an expected edge count and wait for the monitor
   task automatic measure(input int ch, input int expv, input string tag);
      int target;
      repeat (60) @(negedge clk);
      target = done_cnt + 1;
      ch_q.push_back(ch); exp_q.push_back(expv); tag_q.push_back(tag);
      while (done_cnt < target) @(negedge clk);
   endtask

   // Monitor: count rising edges of the chosen output over WIN cycles
   initial begin
      forever begin
         int ch, expv, edges;
         string tag;
         logic prev, cur;
         while (ch_q.size() == 0) @(negedge clk);
         ch = ch_q.pop_front(); expv = exp_q.pop_front(); tag = tag_q.pop_front();
         edges = 0;
         prev = (ch == 0) ? obs_clk_o : (ch == 1) ? aux_clk_o : bp_clk_o;
         for (int k = 0; k < WIN; k++) begin
            @(negedge clk);
            cur = (ch == 0) ? obs_clk_o : (ch == 1) ? aux_clk_o : bp_clk_o;
            if (cur && !prev) edges++;
            prev = cur;
         end
         chk(tag, edges, expv, 1);
         done_cnt++;
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DATA_W-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(32'h104, v); chk("R1 sel reset", int'(v), 0, 0);
      rd(32'h124, v); chk("R1 obs div reset", int'(v), 0, 0);
      rd(32'h12C, v); chk("R1 bp div reset", int'(v), 0, 0);
      rd(32'h148, v); chk("R1 gate reset", int'(v), 0, 0);
      measure(0, 0, "R1 obs low after reset");
      measure(1, 0, "R1 aux low after reset");

      // R8: unmapped read and masked readback
      rd(32'h100, v); chk("R8 unmapped read", int'(v), 0, 0);
      wr(32'h124, 32'hFFFF_7FE0);
      rd(32'h124, v); chk("R8 obs div masked", int'(v), 0, 0);
      wr(32'h148, 32'hFFFF_FFFC);
      rd(32'h148, v); chk("R8 gate masked", int'(v), 0, 0);

      // R2 / R9: source 0 (period 4)
      wr(32'h104, 32'd0);
      wr(32'h124, 32'h0000_8000);
      wr(32'h148, 32'h2);
      measure(0, 500, "R9 divide by 1");
      wr(32'h124, 32'h0000_8004);
      measure(0, 100, "R2 divide by 5");
      wr(32'h124, 32'h0000_801F);
      rd(32'h124, v); chk("R8 obs div readback", int'(v), 32'h801F, 0);
      measure(0, 15, "R9 divide by 32");

      // R6: select write while the gate is open is dropped
      wr(32'h124, 32'h0000_8000);
      wr(32'h104, 32'd2);
      rd(32'h104, v); chk("R6 sel unchanged", int'(v), 0, 0);
      measure(0, 500, "R6 source unchanged");

      // R5: switch with the gate closed
      wr(32'h148, 32'h0);
      wr(32'h104, 32'd1);
      rd(32'h104, v); chk("R5 sel readback", int'(v), 1, 0);
      wr(32'h124, 32'h0000_8001);
      wr(32'h148, 32'h2);
      measure(0, 166, "R5 source 1 div 2");
      wr(32'h148, 32'h0);
      wr(32'h104, 32'd3);
      wr(32'h124, 32'h0000_8000);
      wr(32'h148, 32'h2);
      measure(0, 142, "R5 source 3 div 1");

      // R3: enable bit clear holds output low
      wr(32'h124, 32'h0000_0000);
      measure(0, 0, "R3 divider disabled");

      // R4: gates
      wr(32'h124, 32'h0000_8000);
      wr(32'h148, 32'h0);
      measure(0, 0, "R4 obs gate closed");
      wr(32'h148, 32'h1);
      measure(1, 250, "R4 aux undivided");
      measure(0, 0, "R4 obs still gated");
      wr(32'h148, 32'h0);
      measure(1, 0, "R4 aux gated");

      // R7: bypass divider
      measure(2, 250, "R7 bypass div 1");
      wr(32'h12C, 32'd3);
      rd(32'h12C, v); chk("R7 bypass readback", int'(v), 3, 0);
      measure(2, 62, "R7 bypass div 4");

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule